// File: doc/BRIEF.md
# Block-Floating-Point Barrel Shifter

This block is a single-cycle shifter for a 16-bit fixed-point data path. Each cycle it takes one 16-bit word, a signed shift amount, an operation code and two placement controls. It writes a registered 32-bit result. The word is first placed in the upper or lower half of a 32-bit field. That field is then shifted left for positive amounts or right for negative amounts, with either zero fill or sign fill.

Block floating-point work uses two further registers. The detected-exponent register holds the negated count of redundant sign bits of a word. The block exponent register tracks the largest such exponent over a run of samples. Software clears the block register and then feeds the samples of a block through the block-detect operation. It reads back the common exponent and scales each sample by it. Normalization shifts a word left by its own redundant sign count in a single cycle.

A two-state tracker controls the block register. In BLK_EMPTY no sample has been seen since the last clear. In BLK_TRACK at least one has been seen. The transitions are:
- EMPTY to TRACK on a block detect.
- TRACK to EMPTY on a block clear.
- TRACK stays in TRACK on a further block detect.
- EMPTY stays in EMPTY on a further clear.

Top module: `bfp_shifter`

## Requirements
- R1: After reset `result` is 0, `exp_out` is 0, `blk_exp` is 0 and the block tracker is in BLK_EMPTY.
- R2: Opcode 1 (logical shift) places `in_word` in bits 31:16 when `hi_sel`=1, or zero-extended in bits 15:0 when `hi_sel`=0. It then shifts left by `shift_amt` when that is positive and right by its magnitude when it is negative, filling with zeros.
- R3: Opcode 2 (arithmetic shift) is the same as opcode 1, except that the low placement sign-extends the word and a right shift fills with bit 31 of the placed field.
- R4: A shift magnitude of 32 or more gives 0 for left shifts and logical right shifts, and gives 32 copies of the placed sign bit for arithmetic right shifts. A magnitude of 31 still moves one bit through.
- R5: When `or_mode`=1, a shift or normalize result is ORed into the current `result` instead of replacing it.
- R6: Opcode 4 (exponent detect) sets `exp_out` to minus the number of bits below bit 15 that equal bit 15, counted from bit 14 downward. The value ranges from 0 to -15, and both 0x0000 and 0xFFFF give -15. `result` is unchanged.
- R7: Opcode 6 (block clear) sets `blk_exp` to 0 and moves the tracker to BLK_EMPTY. The first block detect after it loads the word's exponent, even when that exponent is negative.
- R8: Opcode 5 (block detect) sets `exp_out` to the word's exponent. In BLK_TRACK it replaces `blk_exp` only when the new exponent is greater, that is, nearer zero.
- R9: Opcode 3 (normalize) places the word with sign extension and shifts it left by its redundant sign count. It also sets `exp_out` to the word's exponent.
- R10: Opcode 7 (exponent adjust) adds `shift_amt` to `exp_out` and saturates the sum to the range -16..15. `result` and `blk_exp` are unchanged.
- R11: Opcode 0 (no operation) leaves all outputs unchanged. Every operation's effect appears on the outputs after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 3 | Operation code (0 nop, 1 logical, 2 arithmetic, 3 normalize, 4 detect, 5 block detect, 6 block clear, 7 adjust) |
| in_word | input | 16 | Data word |
| shift_amt | input | 7 | Signed shift amount, or the adjust value for opcode 7 |
| hi_sel | input | 1 | 1 places the word in bits 31:16, 0 in bits 15:0 |
| or_mode | input | 1 | 1 ORs the new result into the result register |
| result | output | 32 | Result register |
| exp_out | output | 5 | Signed detected-exponent register |
| blk_exp | output | 5 | Signed block exponent register |

## Verification
The assertions check on every cycle the properties that hold for any input:
- Non-shifting opcodes hold `result`.
- A clear zeroes the block register.
- In BLK_TRACK the block register never decreases and never falls below the exponent just detected.
- Detected exponents stay within 0..-15.
- A plain high-half normalize of a non-trivial word leaves bits 31 and 30 different.

The exact shifted patterns need the bench's directed scenarios. These include the fill at magnitudes 31, 32 and beyond, the merge in OR mode, the load-on-first-sample rule after a clear, and the saturation points of exponent adjust.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LSH    = 3'd1,
        OP_ASH    = 3'd2,
        OP_NORM   = 3'd3,
        OP_EXPD   = 3'd4,
        OP_BEXPD  = 3'd5,
        OP_BCLR   = 3'd6,
        OP_EXPADJ = 3'd7
    } bfp_op_e;

    typedef enum logic {
        BLK_EMPTY = 1'b0,
        BLK_TRACK = 1'b1
    } blk_state_e;
endpackage

// File: rtl/bfp_expdet.sv
// Exponent detector: returns minus the count of redundant sign bits.
module bfp_expdet #(
    parameter int DW = 16,
    parameter int EW = $clog2(DW) + 1
) (
    input  logic [DW-1:0]        word,
    output logic signed [EW-1:0] exp_val
);
    localparam int LW = $clog2(DW);

    logic [LW-1:0] rsb;
    logic          run;

    always_comb begin
        rsb = '0;
        run = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (run && (word[i] == word[DW-1])) begin
                rsb = rsb + LW'(1);
            end else begin
                run = 1'b0;
            end
        end
    end

    assign exp_val = -$signed({1'b0, rsb});
endmodule

// File: rtl/bfp_shift_core.sv
// Placement and bidirectional shift of one word into a double-width field.
module bfp_shift_core #(
    parameter int DW = 16,
    parameter int AW = 7
) (
    input  logic [DW-1:0]        word,
    input  logic signed [AW-1:0] amt,
    input  logic                 arith,
    input  logic                 hi,
    output logic [2*DW-1:0]      shifted
);
    localparam int RW = 2 * DW;
    localparam logic [AW-1:0] RW_LIM = AW'(RW);

    logic [RW-1:0] base;
    logic [AW-1:0] mag;
    logic          big;
    logic          go_right;

    always_comb begin
        if (hi) begin
            base = {word, {DW{1'b0}}};
        end else if (arith) begin
            base = {{DW{word[DW-1]}}, word};
        end else begin
            base = {{DW{1'b0}}, word};
        end
    end

    assign go_right = amt[AW-1];
    assign mag      = go_right ? (~amt + AW'(1)) : amt;
    assign big      = (mag >= RW_LIM);

    always_comb begin
        if (!go_right) begin
            shifted = big ? '0 : (base << mag);
        end else if (arith) begin
            shifted = big ? {RW{base[RW-1]}} : RW'($signed(base) >>> mag);
        end else begin
            shifted = big ? '0 : (base >> mag);
        end
    end
endmodule

// File: rtl/bfp_shifter.sv
module bfp_shifter
    import bfp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [2:0]                        opcode,
    input  logic [DW-1:0]                     in_word,
    input  logic signed [AW-1:0]              shift_amt,
    input  logic                              hi_sel,
    input  logic                              or_mode,
    output logic [2*DW-1:0]                   result,
    output logic signed [$clog2(DW):0]        exp_out,
    output logic signed [$clog2(DW):0]        blk_exp
);
    localparam int RW = 2 * DW;
    localparam int EW = $clog2(DW) + 1;
    localparam int SW = AW + 1;
    localparam logic signed [SW-1:0] EXP_MAX = SW'((1 << (EW - 1)) - 1);
    localparam logic signed [SW-1:0] EXP_MIN = -EXP_MAX - SW'(1);

    bfp_op_e             op;
    blk_state_e          blk_st_q, blk_st_d;
    logic [RW-1:0]       result_q;
    logic signed [EW-1:0] exp_q, blk_q, det_exp, adj_sat;
    logic signed [AW-1:0] core_amt, norm_amt;
    logic signed [SW-1:0] adj_sum;
    logic [RW-1:0]       sh_out;
    logic                use_arith;

    assign op = bfp_op_e'(opcode);

    bfp_expdet #(.DW(DW), .EW(EW)) u_det (
        .word    (in_word),
        .exp_val (det_exp)
    );

    assign norm_amt  = -$signed({{(AW-EW){det_exp[EW-1]}}, det_exp});
    assign core_amt  = (op == OP_NORM) ? norm_amt : shift_amt;
    assign use_arith = (op == OP_ASH) || (op == OP_NORM);

    bfp_shift_core #(.DW(DW), .AW(AW)) u_core (
        .word    (in_word),
        .amt     (core_amt),
        .arith   (use_arith),
        .hi      (hi_sel),
        .shifted (sh_out)
    );

    assign adj_sum = $signed({{(SW-EW){exp_q[EW-1]}}, exp_q})
                   + $signed({shift_amt[AW-1], shift_amt});

    always_comb begin
        if (adj_sum > EXP_MAX) begin
            adj_sat = EXP_MAX[EW-1:0];
        end else if (adj_sum < EXP_MIN) begin
            adj_sat = EXP_MIN[EW-1:0];
        end else begin
            adj_sat = adj_sum[EW-1:0];
        end
    end

    // Block tracker: next state
    always_comb begin
        blk_st_d = blk_st_q;
        unique case (blk_st_q)
            BLK_EMPTY: if (op == OP_BEXPD) blk_st_d = BLK_TRACK;
            BLK_TRACK: if (op == OP_BCLR)  blk_st_d = BLK_EMPTY;
            default:   blk_st_d = BLK_EMPTY;
        endcase
    end

    // Block tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_st_q <= BLK_EMPTY;
        end else begin
            blk_st_q <= blk_st_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            exp_q    <= '0;
            blk_q    <= '0;
        end else begin
            unique case (op)
                OP_LSH, OP_ASH: begin
                    result_q <= or_mode ? (result_q | sh_out) : sh_out;
                end
                OP_NORM: begin
                    result_q <= or_mode ? (result_q | sh_out) : sh_out;
                    exp_q    <= det_exp;
                end
                OP_EXPD: begin
                    exp_q <= det_exp;
                end
                OP_BEXPD: begin
                    exp_q <= det_exp;
                    if ((blk_st_q == BLK_EMPTY) || (det_exp > blk_q)) begin
                        blk_q <= det_exp;
                    end
                end
                OP_BCLR: begin
                    blk_q <= '0;
                end
                OP_EXPADJ: begin
                    exp_q <= adj_sat;
                end
                default: begin
                end
            endcase
        end
    end

    assign result  = result_q;
    assign exp_out = exp_q;
    assign blk_exp = blk_q;
endmodule

// File: rtl/bfp_shifter_chk.sv
module bfp_shifter_chk
    import bfp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 opcode,
    input logic [DW-1:0]              in_word,
    input logic                       hi_sel,
    input logic                       or_mode,
    input logic [2*DW-1:0]            result,
    input logic signed [$clog2(DW):0] exp_out,
    input logic signed [$clog2(DW):0] blk_exp,
    input blk_state_e                 blk_st
);
    localparam int EW = $clog2(DW) + 1;
    localparam logic signed [EW-1:0] LOWEST = EW'(-(DW - 1));

    logic no_shift_op;
    assign no_shift_op = (opcode == OP_NOP) || (opcode == OP_EXPD) ||
                         (opcode == OP_BEXPD) || (opcode == OP_BCLR) ||
                         (opcode == OP_EXPADJ);

    // R10 / R11: opcodes that do not shift leave the result alone
    p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        no_shift_op |=> $stable(result));

    // R7: clear zeroes the block register and empties the tracker
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_BCLR) |=> (blk_exp == '0) && (blk_st == BLK_EMPTY));

    // R8: while tracking, the block exponent never decreases
    p_blk_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_st == BLK_TRACK) && (opcode != OP_BCLR) |=> (blk_exp >= $past(blk_exp)));

    // R8: after a block detect the block value is at least the detected one
    p_blk_ge_det_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_BEXPD) |=> (blk_exp >= exp_out));

    // R6: detected exponents stay within 0 .. -(DW-1)
    p_det_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OP_EXPD) || (opcode == OP_BEXPD) || (opcode == OP_NORM))
        |=> (exp_out <= 0) && (exp_out >= LOWEST));

    // R9: a plain high-half normalize leaves no redundant sign bit
    p_norm_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_NORM) && hi_sel && !or_mode &&
        (in_word != '0) && (in_word != '1)
        |=> (result[2*DW-1] != result[2*DW-2]));
endmodule

bind bfp_shifter bfp_shifter_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .opcode  (opcode),
    .in_word (in_word),
    .hi_sel  (hi_sel),
    .or_mode (or_mode),
    .result  (result),
    .exp_out (exp_out),
    .blk_exp (blk_exp),
    .blk_st  (blk_st_q)
);

// File: tb/sim_bfp_shifter.sv
`timescale 1ns/1ps
module sim_bfp_shifter;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        opcode = 3'd0;
    logic [15:0]       in_word = '0;
    logic signed [6:0] shift_amt = '0;
    logic              hi_sel = 1'b0;
    logic              or_mode = 1'b0;
    logic [31:0]       result;
    logic signed [4:0] exp_out;
    logic signed [4:0] blk_exp;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    bfp_shifter u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .in_word(in_word),
        .shift_amt(shift_amt), .hi_sel(hi_sel), .or_mode(or_mode),
        .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
    );

    function automatic int ref_exp(input logic [15:0] w);
        int n = 0;
        for (int i = 14; i >= 0; i--) begin
            if (w[i] != w[15]) break;
            n++;
        end
        return -n;
    endfunction

    function automatic logic [31:0] ref_sh(input logic [15:0] w, input int amt,
                                           input bit arith, input bit hi);
        logic [31:0] b, r;
        b = hi ? {w, 16'h0} : (arith ? {{16{w[15]}}, w} : {16'h0, w});
        for (int i = 0; i < 32; i++) begin
            int s = i - amt;
            if (s < 0)       r[i] = 1'b0;
            else if (s > 31) r[i] = (arith && amt < 0) ? b[31] : 1'b0;
            else             r[i] = b[s];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [15:0] w, input int amt,
                         input bit hi, input bit orm);
        @(negedge clk);
        opcode = op; in_word = w; shift_amt = 7'(amt); hi_sel = hi; or_mode = orm;
        @(posedge clk);
        #1;
        opcode = 3'd0;
    endtask

    task automatic t_reset;
        chk("R1 result", result, 32'h0);
        chk("R1 exp_out", 32'($signed(exp_out)), 32'h0);
        chk("R1 blk_exp", 32'($signed(blk_exp)), 32'h0);
        do_op(3'd5, 16'h0100, 0, 0, 0);   // first detect loads: tracker was empty
        chk("R1 empty after reset", 32'($signed(blk_exp)), 32'(-6));
        do_op(3'd6, 16'h0, 0, 0, 0);
    endtask

    task automatic t_logical;
        do_op(3'd1, 16'h8001, 0, 1, 0);  chk("R2 hi amt0", result, 32'h80010000);
        do_op(3'd1, 16'h8001, 4, 0, 0);  chk("R2 lo left4", result, 32'h00080010);
        do_op(3'd1, 16'h8001, -8, 1, 0); chk("R2 hi right8", result, 32'h00800100);
        do_op(3'd1, 16'h8001, -1, 0, 0); chk("R2 lo right1", result, ref_sh(16'h8001, -1, 0, 0));
    endtask

    task automatic t_arith;
        do_op(3'd2, 16'h8001, 0, 0, 0);  chk("R3 lo signext", result, 32'hFFFF8001);
        do_op(3'd2, 16'h8000, -4, 1, 0); chk("R3 hi right4", result, 32'hF8000000);
        do_op(3'd2, 16'h7000, -4, 0, 0); chk("R3 pos right4", result, 32'h00000700);
        do_op(3'd2, 16'hA5C3, 3, 0, 0);  chk("R3 lo left3", result, ref_sh(16'hA5C3, 3, 1, 0));
    endtask

    task automatic t_limits;
        do_op(3'd1, 16'hFFFF, 32, 0, 0);  chk("R4 left32", result, 32'h0);
        do_op(3'd1, 16'hFFFF, 31, 0, 0);  chk("R4 left31", result, 32'h80000000);
        do_op(3'd2, 16'h8000, -32, 1, 0); chk("R4 ash right32", result, 32'hFFFFFFFF);
        do_op(3'd2, 16'h8000, -40, 1, 0); chk("R4 ash right40", result, 32'hFFFFFFFF);
        do_op(3'd1, 16'hFFFF, -32, 1, 0); chk("R4 lsh right32", result, 32'h0);
        do_op(3'd1, 16'h8000, -31, 1, 0); chk("R4 lsh right31", result, 32'h00000001);
        do_op(3'd2, 16'h1234, 40, 1, 0);  chk("R4 ash left40", result, 32'h0);
        do_op(3'd2, 16'h4000, -64, 1, 0); chk("R4 ash right64 pos", result, 32'h0);
    endtask

    task automatic t_or;
        do_op(3'd1, 16'h00F0, 0, 1, 0); chk("R5 base", result, 32'h00F00000);
        do_op(3'd1, 16'h0F00, 0, 0, 1); chk("R5 or merge", result, 32'h00F00F00);
        do_op(3'd2, 16'h8000, -16, 1, 1); chk("R5 or arith", result, 32'hFFFF8F00);
    endtask

    task automatic t_expd;
        logic [31:0] keep;
        keep = result;
        do_op(3'd4, 16'h4000, 0, 0, 0); chk("R6 0x4000", 32'($signed(exp_out)), 32'(0));
        do_op(3'd4, 16'h0001, 0, 0, 0); chk("R6 0x0001", 32'($signed(exp_out)), 32'(-14));
        do_op(3'd4, 16'h0000, 0, 0, 0); chk("R6 zero", 32'($signed(exp_out)), 32'(-15));
        do_op(3'd4, 16'hFFFF, 0, 0, 0); chk("R6 ones", 32'($signed(exp_out)), 32'(-15));
        do_op(3'd4, 16'hC000, 0, 0, 0); chk("R6 0xC000", 32'($signed(exp_out)), 32'(ref_exp(16'hC000)));
        chk("R6 result held", result, keep);
    endtask

    task automatic t_block;
        do_op(3'd6, 16'h0, 0, 0, 0);    chk("R7 clear", 32'($signed(blk_exp)), 32'h0);
        do_op(3'd5, 16'h0010, 0, 0, 0); chk("R7 first load", 32'($signed(blk_exp)), 32'(-10));
        do_op(3'd5, 16'h0100, 0, 0, 0); chk("R8 larger kept", 32'($signed(blk_exp)), 32'(-6));
        do_op(3'd5, 16'h0001, 0, 0, 0); chk("R8 smaller ignored", 32'($signed(blk_exp)), 32'(-6));
        chk("R8 exp_out", 32'($signed(exp_out)), 32'(-14));
        do_op(3'd5, 16'hF000, 0, 0, 0); chk("R8 negative word", 32'($signed(blk_exp)), 32'(-3));
        do_op(3'd6, 16'h0, 0, 0, 0);    chk("R7 clear again", 32'($signed(blk_exp)), 32'h0);
        do_op(3'd5, 16'h0000, 0, 0, 0); chk("R7 reload -15", 32'($signed(blk_exp)), 32'(-15));
    endtask

    task automatic t_norm;
        do_op(3'd3, 16'h0300, 0, 1, 0); chk("R9 hi result", result, 32'h60000000);
        chk("R9 hi exp", 32'($signed(exp_out)), 32'(-5));
        do_op(3'd3, 16'hFFF0, 0, 0, 0);
        chk("R9 lo result", result, ref_sh(16'hFFF0, -ref_exp(16'hFFF0), 1, 0));
        chk("R9 lo exp", 32'($signed(exp_out)), 32'(-11));
    endtask

    task automatic t_adjust;
        logic [31:0] keep_r;
        logic [31:0] keep_b;
        do_op(3'd4, 16'h0300, 0, 0, 0);
        keep_r = result;
        keep_b = 32'($signed(blk_exp));
        do_op(3'd7, 16'h0, 3, 0, 0);   chk("R10 add3", 32'($signed(exp_out)), 32'(-2));
        do_op(3'd7, 16'h0, 40, 0, 0);  chk("R10 sat high", 32'($signed(exp_out)), 32'(15));
        do_op(3'd7, 16'h0, -64, 0, 0); chk("R10 sat low", 32'($signed(exp_out)), 32'(-16));
        chk("R10 result held", result, keep_r);
        chk("R10 blk held", 32'($signed(blk_exp)), keep_b);
    endtask

    task automatic t_nop;
        logic [31:0] r0, e0, b0;
        r0 = result; e0 = 32'($signed(exp_out)); b0 = 32'($signed(blk_exp));
        do_op(3'd0, 16'hFFFF, 5, 1, 1);
        chk("R11 nop result", result, r0);
        chk("R11 nop exp", 32'($signed(exp_out)), e0);
        chk("R11 nop blk", 32'($signed(blk_exp)), b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_logical();
        t_arith();
        t_limits();
        t_or();
        t_expd();
        t_block();
        t_norm();
        t_adjust();
        t_nop();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule